// File: doc/BRIEF.md
# Gated 16-bit Timer with Sleep Wake

This block is a 16-bit up-counter under a byte-wide register interface. It advances on the core clock or on an external clock input. The count passes through a prescaler with a selectable division ratio. It can also be held by a gate input whose active level is selectable. When it wraps from all ones to zero, it records the event in a sticky flag. If the enables allow, it then raises a wake request for a sleeping core and a take-interrupt output.

In one mode the external input clocks the counter directly, with no synchronizer. The counter then keeps advancing, and can wake the core, while the core clock is stopped. In every other mode the counter is frozen while the core sleeps. Count bytes are read through a stable snapshot while the counter runs from the unsynchronized clock. Firmware stops the timer before it rewrites the count.

Top module: `tmr_gated_top`

## Requirements
- R1: Register addresses: 0 is the count low byte, 1 the count high byte, 2 the control byte, 3 the flag byte (bit 0 is the overflow flag, other bits read 0). Read data is combinational from the address. The control bits are: 7 gate invert, 6 gate enable, 5:4 prescale select, 3 oscillator enable (stored only, reads back), 2 synchronizer bypass, 1 external clock select, 0 timer run.
- R2: Reset (rstN low) clears the control byte, the overflow flag, wakeReq and takeIrq. The 16-bit count keeps its value across a reset.
- R3: With run set and the internal clock selected (bit 1 = 0), the count advances on core clock edges. N edges after the control write it equals start + N / ratio. It never steps by more than one. With run clear it holds.
- R4: Prescale select 00, 01, 10 and 11 divide by 1, 2, 4 and 8. A write to either count byte clears the prescaler.
- R5: A wrap from 0xFFFF to 0x0000 sets the overflow flag. The flag reads as 1 within 3 core clock edges after the wrap.
- R6: With gate enable set, counting happens only while gateIn equals the gate invert bit (active low when invert is 0, active high when it is 1). With gate enable clear, gateIn has no effect.
- R7: With external select set and the bypass clear, each rising edge of extClkIn that stays high and low for at least 2 core clocks advances the count once, through a synchronizer.
- R8: While coreSleep is high, the count does not advance in internal or synchronized external mode.
- R9: With run, external select and bypass all set, each rising edge of extClkIn advances the count directly, even with the core clock stopped. Count reads then return a stable snapshot that lags by at most 3 core clocks. Count byte writes in this state are ignored.
- R10: wakeReq is high while an overflow is pending (flagged or just occurred) and run, timerIe and periphIe are all high. It rises as soon as the wrap happens, without a core clock edge.
- R11: takeIrq equals wakeReq qualified by globalIe.
- R12: The flag is sticky: only a write of 0 to bit 0 of the flag byte clears it, and a write of 1 sets it. A new overflow wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, stopped by the system during sleep |
| rstN | input | 1 | Active-low asynchronous reset |
| coreSleep | input | 1 | High while the core is in sleep |
| extClkIn | input | 1 | External count clock |
| gateIn | input | 1 | Count gate input |
| globalIe | input | 1 | Global interrupt enable |
| periphIe | input | 1 | Peripheral interrupt enable |
| timerIe | input | 1 | Timer overflow interrupt enable |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| wakeReq | output | 1 | Wake request on enabled overflow |
| takeIrq | output | 1 | Wake request that should vector to the interrupt handler |

## Verification
On every edge of its counting clock, the assertions check four things: the count steps by at most one, it holds when no tick is qualified, a wrap toggles the overflow event, and a set flag survives any cycle without a clearing write. In internal and synchronized modes they also check that the count does not move while the core sleeps. Only the bench scenarios can show the exact division ratios, the gate polarity, the synchronized edge count, the wake with the core clock halted, the snapshot reads in the unsynchronized mode and the count kept across a reset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_BYTES = 2;
  localparam int CNT_W = 8 * CNT_BYTES;
  localparam int PSEL_W = 2;
  localparam int PRE_W = (1 << PSEL_W) - 1;
  localparam int ADDR_W = $clog2(CNT_BYTES + 2);
  localparam int ADDR_CTRL = CNT_BYTES;
  localparam int ADDR_FLAG = CNT_BYTES + 1;

  typedef struct packed {
    logic gateInv;
    logic gateEn;
    logic [PSEL_W-1:0] preSel;
    logic oscEn;
    logic syncOff;
    logic extSel;
    logic run;
  } ctrlReg_t;

  typedef struct packed {
    logic incQual;
    logic [CNT_BYTES-1:0] loadByte;
    logic [7:0] loadData;
    logic [PSEL_W-1:0] preSel;
  } strobe_t;
endpackage

// File: rtl/tmr_count_path.sv
module tmr_count_path
  import tmr_pkg::*;
(
  input  logic tickClk,
  input  logic rstN,
  input  strobe_t stb,
  output logic [CNT_W-1:0] count,
  output logic ovfTog
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic [CNT_W-1:0] nextCount;
  logic tickDone;
  logic anyLoad;
  logic pastOk;

  assign preLimit = PRE_W'((1 << stb.preSel) - 1);
  assign anyLoad = |stb.loadByte;
  assign tickDone = stb.incQual && !anyLoad && (preCnt >= preLimit);
  assign nextCount = count + CNT_W'(1);

  // prescaler and overflow event toggle
  always_ff @(posedge tickClk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      ovfTog <= 1'b0;
      pastOk <= 1'b0;
    end else begin
      pastOk <= 1'b1;
      if (anyLoad) begin
        preCnt <= '0;
      end else if (stb.incQual) begin
        preCnt <= tickDone ? '0 : preCnt + PRE_W'(1);
      end
      if (tickDone && (count == '1)) begin
        ovfTog <= ~ovfTog;
      end
    end
  end

  // count bytes keep their value across reset
  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_byte
    always_ff @(posedge tickClk) begin
      if (stb.loadByte[b]) begin
        count[b*8 +: 8] <= stb.loadData;
      end else if (tickDone) begin
        count[b*8 +: 8] <= nextCount[b*8 +: 8];
      end
    end
  end

  // R3: never more than one step per counting edge
  a_r3_step_one: assert property (@(posedge tickClk) disable iff (!rstN)
    (pastOk && !anyLoad) |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

  // R3: no qualified tick, no change
  a_r3_hold_no_tick: assert property (@(posedge tickClk) disable iff (!rstN)
    (pastOk && !stb.incQual && !anyLoad) |=> $stable(count));

  // R5: a wrap to zero is reported as an overflow event
  a_r5_wrap_toggles: assert property (@(posedge tickClk) disable iff (!rstN)
    (pastOk && !$past(anyLoad) && $past(count) == '1 && count == '0) |-> (ovfTog != $past(ovfTog)));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic coreSleep,
  input  logic extClkIn,
  input  logic gateIn,
  input  logic globalIe,
  input  logic periphIe,
  input  logic timerIe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic [CNT_W-1:0] count,
  input  logic ovfTog,
  output strobe_t stb,
  output logic asyncRun,
  output logic wakeReq,
  output logic takeIrq
);
  ctrlReg_t ctrlR;
  logic ovfFlag;
  logic seenTog;
  logic ovfS1, ovfS2;
  logic ext1, ext2, ext3;
  logic extRise;
  logic gateOk;
  logic syncTick;
  logic ovfPend;
  logic flagWr;
  logic [CNT_W-1:0] snapA, snapB, snapHold;
  logic [CNT_W-1:0] rdCount;

  assign asyncRun = ctrlR.run && ctrlR.extSel && ctrlR.syncOff;
  assign gateOk = !ctrlR.gateEn || (gateIn == ctrlR.gateInv);
  assign extRise = ext2 && !ext3;
  assign syncTick = !coreSleep && (ctrlR.extSel ? extRise : 1'b1);
  assign flagWr = regWrEn && (regAddr == ADDR_W'(ADDR_FLAG));

  // strobes toward the count path
  always_comb begin
    stb.incQual = ctrlR.run && gateOk && (asyncRun || syncTick);
    stb.loadData = regWrData;
    stb.preSel = ctrlR.preSel;
    for (int b = 0; b < CNT_BYTES; b++) begin
      stb.loadByte[b] = regWrEn && !asyncRun && (regAddr == ADDR_W'(b));
    end
  end

  // control register and external clock synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlR <= '0;
      ext1 <= 1'b0;
      ext2 <= 1'b0;
      ext3 <= 1'b0;
    end else begin
      ext1 <= extClkIn;
      ext2 <= ext1;
      ext3 <= ext2;
      if (regWrEn && (regAddr == ADDR_W'(ADDR_CTRL))) begin
        ctrlR <= ctrlReg_t'(regWrData);
      end
    end
  end

  // overflow event handoff into the core domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfS1 <= 1'b0;
      ovfS2 <= 1'b0;
      seenTog <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      ovfS1 <= ovfTog;
      ovfS2 <= ovfS1;
      seenTog <= ovfS2;
      if (ovfS2 != seenTog) begin
        ovfFlag <= 1'b1;
      end else if (flagWr) begin
        ovfFlag <= regWrData[0];
      end
    end
  end

  // stable snapshot for reads of a count on a foreign clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapA <= '0;
      snapB <= '0;
      snapHold <= '0;
    end else begin
      snapA <= count;
      snapB <= snapA;
      if (snapA == snapB) begin
        snapHold <= snapB;
      end
    end
  end

  assign rdCount = asyncRun ? snapHold : count;

  always_comb begin
    regRdData = '0;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (regAddr == ADDR_W'(b)) begin
        regRdData = rdCount[b*8 +: 8];
      end
    end
    if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      regRdData = ctrlR;
    end
    if (regAddr == ADDR_W'(ADDR_FLAG)) begin
      regRdData = {7'b0, ovfFlag};
    end
  end

  // pending covers a wrap not yet seen by the core clock
  assign ovfPend = ovfFlag || (ovfTog != seenTog);
  assign wakeReq = ovfPend && ctrlR.run && timerIe && periphIe;
  assign takeIrq = wakeReq && globalIe;

  // R12: flag survives every cycle without a clearing write
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(flagWr && !regWrData[0])) |=> ovfFlag);
endmodule

// File: rtl/tmr_gated_top.sv
module tmr_gated_top
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic coreSleep,
  input  logic extClkIn,
  input  logic gateIn,
  input  logic globalIe,
  input  logic periphIe,
  input  logic timerIe,
  input  logic [1:0] regAddr,
  input  logic regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic wakeReq,
  output logic takeIrq
);
  strobe_t stb;
  logic asyncRun;
  logic tickClk;
  logic [CNT_W-1:0] countW;
  logic ovfTog;

  // counting clock: external pin when running unsynchronized
  assign tickClk = asyncRun ? extClkIn : clk;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .coreSleep(coreSleep), .extClkIn(extClkIn),
    .gateIn(gateIn), .globalIe(globalIe), .periphIe(periphIe), .timerIe(timerIe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .count(countW), .ovfTog(ovfTog), .stb(stb),
    .asyncRun(asyncRun), .wakeReq(wakeReq), .takeIrq(takeIrq)
  );

  tmr_count_path u_path (
    .tickClk(tickClk), .rstN(rstN), .stb(stb), .count(countW), .ovfTog(ovfTog)
  );

  // R8: synchronized modes are frozen while the core sleeps
  a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rstN)
    (coreSleep && !asyncRun && !regWrEn) |=> $stable(countW));
endmodule

// File: tb/tmr_gated_top_test.sv
module tmr_gated_top_test;
  logic clk = 1'b0;
  logic clkRun = 1'b1;
  logic rstN = 1'b0;
  logic coreSleep = 1'b0;
  logic extClkIn = 1'b0;
  logic gateIn = 1'b0;
  logic globalIe = 1'b0;
  logic periphIe = 1'b0;
  logic timerIe = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic wakeReq, takeIrq;
  int checks = 0;
  int errors = 0;

  tmr_gated_top uut (
    .clk(clk), .rstN(rstN), .coreSleep(coreSleep), .extClkIn(extClkIn),
    .gateIn(gateIn), .globalIe(globalIe), .periphIe(periphIe), .timerIe(timerIe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .wakeReq(wakeReq), .takeIrq(takeIrq)
  );

  always #4 clk = clkRun ? ~clk : 1'b0;

  typedef struct packed {
    logic [7:0] ctrlV;
    logic [15:0] startV;
    logic gateV;
    logic [7:0] nCyc;
    logic [15:0] expV;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'h01, 16'h1234, 1'b0, 8'd10, 16'h123E},
    '{8'h11, 16'h0100, 1'b0, 8'd20, 16'h010A},
    '{8'h21, 16'h0000, 1'b0, 8'd20, 16'h0005},
    '{8'h31, 16'h00F0, 1'b0, 8'd40, 16'h00F5},
    '{8'h41, 16'h0500, 1'b1, 8'd10, 16'h0500},
    '{8'h41, 16'h0500, 1'b0, 8'd10, 16'h050A},
    '{8'hC1, 16'h0700, 1'b1, 8'd7,  16'h0707},
    '{8'hC1, 16'h0700, 1'b0, 8'd7,  16'h0700},
    '{8'h81, 16'h0800, 1'b1, 8'd5,  16'h0805},
    '{8'h00, 16'h0900, 1'b0, 8'd10, 16'h0900},
    '{8'h01, 16'h00FE, 1'b0, 8'd4,  16'h0102},
    '{8'h09, 16'h0A00, 1'b0, 8'd3,  16'h0A03}
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    regWrData = d;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic rdCount(output logic [15:0] v);
    logic [7:0] lo, hi;
    rdReg(2'd0, lo);
    rdReg(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic loadCount(input logic [15:0] v);
    wrReg(2'd0, v[7:0]);
    wrReg(2'd1, v[15:8]);
  endtask

  task automatic extPulse();
    @(negedge clk);
    extClkIn = 1'b1;
    repeat (3) @(negedge clk);
    extClkIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] cv;
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    rdReg(2'd2, rb); chk("R2", "ctrl after reset", 16'(rb), 16'h0000);
    rdReg(2'd3, rb); chk("R2", "flag after reset", 16'(rb), 16'h0000);
    chk("R2", "wake after reset", 16'(wakeReq), 16'h0);
    chk("R2", "irq after reset", 16'(takeIrq), 16'h0);

    // vector table: R1 R3 R4 R6
    for (int i = 0; i < NVEC; i++) begin
      wrReg(2'd2, 8'h00);
      loadCount(VECS[i].startV);
      gateIn = VECS[i].gateV;
      wrReg(2'd2, VECS[i].ctrlV);
      repeat (int'(VECS[i].nCyc)) @(negedge clk);
      rdCount(cv);
      chk("R3/R4/R6", $sformatf("vector %0d count", i), cv, VECS[i].expV);
      rdReg(2'd2, rb);
      chk("R1", $sformatf("vector %0d ctrl readback", i), 16'(rb), 16'(VECS[i].ctrlV));
    end
    gateIn = 1'b0;

    // R4 prescaler cleared by a count byte write
    wrReg(2'd2, 8'h00);
    loadCount(16'h0000);
    wrReg(2'd2, 8'h31);
    repeat (5) @(negedge clk);
    wrReg(2'd2, 8'h30);
    wrReg(2'd0, 8'h20);
    wrReg(2'd2, 8'h31);
    repeat (7) @(negedge clk);
    rdCount(cv); chk("R4", "prescaler cleared, 7 ticks", cv, 16'h0020);
    @(negedge clk);
    rdCount(cv); chk("R4", "prescaler cleared, 8 ticks", cv, 16'h0021);

    // R5 R10 R11 R12 overflow in internal mode
    periphIe = 1'b1; timerIe = 1'b1; globalIe = 1'b0;
    wrReg(2'd2, 8'h00);
    wrReg(2'd3, 8'h00);
    loadCount(16'hFFFD);
    wrReg(2'd2, 8'h01);
    repeat (2) @(negedge clk);
    rdCount(cv); chk("R3", "before wrap", cv, 16'hFFFF);
    chk("R10", "no wake before wrap", 16'(wakeReq), 16'h0);
    @(negedge clk);
    rdCount(cv); chk("R5", "wrapped count", cv, 16'h0000);
    chk("R10", "wake at wrap", 16'(wakeReq), 16'h1);
    chk("R11", "no irq with globalIe low", 16'(takeIrq), 16'h0);
    globalIe = 1'b1;
    #1 chk("R11", "irq with globalIe high", 16'(takeIrq), 16'h1);
    repeat (3) @(negedge clk);
    rdReg(2'd3, rb); chk("R5", "flag set", 16'(rb), 16'h0001);
    repeat (10) @(negedge clk);
    rdReg(2'd3, rb); chk("R12", "flag sticky", 16'(rb), 16'h0001);
    timerIe = 1'b0;
    #1 chk("R10", "wake needs timerIe", 16'(wakeReq), 16'h0);
    timerIe = 1'b1;
    wrReg(2'd2, 8'h00);
    chk("R10", "wake needs run", 16'(wakeReq), 16'h0);
    wrReg(2'd3, 8'h00);
    rdReg(2'd3, rb); chk("R12", "flag cleared by write 0", 16'(rb), 16'h0000);
    wrReg(2'd2, 8'h01);
    chk("R12", "wake low after clear", 16'(wakeReq), 16'h0);
    wrReg(2'd3, 8'h01);
    rdReg(2'd3, rb); chk("R12", "flag set by write 1", 16'(rb), 16'h0001);
    chk("R10", "wake from set flag", 16'(wakeReq), 16'h1);
    periphIe = 1'b0;
    #1 chk("R10", "wake needs periphIe", 16'(wakeReq), 16'h0);
    periphIe = 1'b1;
    wrReg(2'd2, 8'h00);
    wrReg(2'd3, 8'h00);

    // R7 synchronized external clock
    loadCount(16'h0010);
    wrReg(2'd2, 8'h03);
    repeat (5) extPulse();
    repeat (4) @(negedge clk);
    rdCount(cv); chk("R7", "five external edges", cv, 16'h0015);

    // R8 sleep freezes synchronized modes
    coreSleep = 1'b1;
    repeat (4) extPulse();
    repeat (4) @(negedge clk);
    rdCount(cv); chk("R8", "external sync during sleep", cv, 16'h0015);
    coreSleep = 1'b0;
    wrReg(2'd2, 8'h00);
    loadCount(16'h0030);
    coreSleep = 1'b1;
    wrReg(2'd2, 8'h01);
    repeat (10) @(negedge clk);
    rdCount(cv); chk("R8", "internal during sleep", cv, 16'h0030);
    coreSleep = 1'b0;
    wrReg(2'd2, 8'h00);

    // R9 unsynchronized external clock with core clock stopped
    globalIe = 1'b1;
    loadCount(16'hFFFE);
    wrReg(2'd2, 8'h07);
    coreSleep = 1'b1;
    clkRun = 1'b0;
    #10 extClkIn = 1'b1;
    #10 extClkIn = 1'b0;
    #10 chk("R10", "no wake after one async edge", 16'(wakeReq), 16'h0);
    extClkIn = 1'b1;
    #10 extClkIn = 1'b0;
    #1 chk("R9", "wake while core clock stopped", 16'(wakeReq), 16'h1);
    chk("R11", "irq while core clock stopped", 16'(takeIrq), 16'h1);
    #10 coreSleep = 1'b0;
    clkRun = 1'b1;
    repeat (5) @(negedge clk);
    rdCount(cv); chk("R9", "snapshot after wake", cv, 16'h0000);
    rdReg(2'd3, rb); chk("R5", "flag after async wrap", 16'(rb), 16'h0001);
    @(negedge clk); extClkIn = 1'b1;
    @(negedge clk); extClkIn = 1'b0;
    repeat (5) @(negedge clk);
    rdCount(cv); chk("R9", "async edge with core running", cv, 16'h0001);
    wrReg(2'd0, 8'h55);
    repeat (5) @(negedge clk);
    rdCount(cv); chk("R9", "count write ignored in async run", cv, 16'h0001);
    wrReg(2'd3, 8'h00);
    chk("R12", "wake low after async clear", 16'(wakeReq), 16'h0);
    wrReg(2'd2, 8'h00);
    rdCount(cv); chk("R9", "count after stop", cv, 16'h0001);

    // R2 count kept across reset, control cleared
    loadCount(16'h4321);
    wrReg(2'd2, 8'h20);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    rdCount(cv); chk("R2", "count kept across reset", cv, 16'h4321);
    rdReg(2'd2, rb); chk("R2", "ctrl cleared by reset", 16'(rb), 16'h0000);

    finishRun();
  end
endmodule